// File: doc/BRIEF.md
# Pointer Register File with Subroutine Linkage

This block holds sixteen 16-bit pointer registers, two 4-bit selectors (`p_sel`, naming the register used as program counter, and `x_sel`, naming the data pointer), an 8-bit link register and the interrupt-enable flag. It carries out the register-level operations of a small 8-bit processor:

- increment and decrement of a register;
- reading the low or high byte of a register out to the accumulator, and writing the accumulator into one byte of a register;
- loading either selector from the operand nibble;
- the two stack transfers through the data pointer;
- the call-side save and the return-side restore of the packed selector pair.

An operation is offered as a 4-bit operation code, a 4-bit operand nibble and the current accumulator byte. It is taken when `op_valid` and `op_ready` are both high. Bytes bound for the accumulator come back on `d_out` with a one-cycle `d_valid` strobe. A simple synchronous memory port, with data returned one cycle after the read strobe, carries the stack byte traffic. Subroutine linkage works by switching selectors rather than by moving addresses. The save pushes the packed selector byte through register 2. The restore pops it through the data pointer and sets or clears the interrupt-enable flag in the same step.

Top module: `ptr_regfile`

## Requirements
- R1: After reset `p_sel` = 0, `x_sel` = 0, `t_reg` = 0, `ie` = 1, `op_ready` = 1, `d_valid` = 0, and register 0 reads back as 16'h0000.
- R2: Operation code 1 adds one to register `op_n` and code 2 subtracts one, both modulo 2^16 (16'hFFFF + 1 = 0, 0 − 1 = 16'hFFFF), in the cycle the operation is taken.
- R3: Code 3 returns bits 7:0 of register `op_n` and code 4 returns bits 15:8 on `d_out`, with `d_valid` high for exactly the cycle after the operation is taken. `d_valid` stays low after every other operation except code 13.
- R4: Code 5 writes `d_in` into bits 7:0 and code 6 writes it into bits 15:8 of register `op_n`; the other byte keeps its value.
- R5: Code 7 loads `op_n` into `p_sel` and code 8 loads `op_n` into `x_sel`, effective the cycle after the operation is taken.
- R6: Code 9 (save) does four things in the cycle it is taken. It drives a memory write of the packed byte {`x_sel`, `p_sel`} (x in bits 7:4, p in bits 3:0) at the address held in register 2. It loads that byte into `t_reg`. It copies `p_sel` into `x_sel`. It decrements register 2. `mem_we` and `mem_re` are never high together.
- R7: Code 10 (restore, enable) and code 11 (restore, disable) drive a memory read at the address in register `x_sel`, increment that register (the old `x_sel`), and set `ie` to 1 or 0 respectively. One cycle later, with `op_ready` low, they load `x_sel` from bits 7:4 and `p_sel` from bits 3:0 of `mem_rdata`.
- R8: Code 12 writes `d_in` to memory at the address in register `x_sel`, then decrements that register.
- R9: Code 13 reads memory at the address in register `x_sel` and increments that register. The byte returned on `mem_rdata` appears on `d_out` with `d_valid` high two cycles after the operation is taken.
- R10: `op_ready` is low for exactly the one cycle after a code 10, 11 or 13 is taken, and high otherwise; an operation offered while `op_ready` is low has no effect.
- R11: Codes 0, 14 and 15 change no register, selector, link byte or flag and issue no memory access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| op_valid | input | 1 | Operation offered this cycle |
| op_ready | output | 1 | Block can take an operation this cycle |
| op_code | input | 4 | Operation code (see requirements) |
| op_n | input | 4 | Operand nibble: register index or selector value |
| d_in | input | 8 | Accumulator byte for byte writes and stores |
| d_out | output | 8 | Byte bound for the accumulator |
| d_valid | output | 1 | `d_out` carries a new byte this cycle |
| mem_addr | output | 16 | Memory byte address |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write data |
| mem_re | output | 1 | Memory read strobe; data due one cycle later |
| mem_rdata | input | 8 | Memory read data |
| p_sel | output | 4 | Program counter register index |
| x_sel | output | 4 | Data pointer register index |
| t_reg | output | 8 | Link byte saved by the last save operation |
| ie | output | 1 | Interrupt-enable flag |

## Verification
The registers are first seeded with random contents. A fixed-seed random mix of all sixteen operation codes then runs over them, so the same register often serves as operand, data pointer and register 2 in turn. This separates index selection faults (N versus X versus 2) from plain arithmetic faults. Directed sequences cover the cases random traffic rarely reaches: increment and decrement across the 16-bit wrap, a save followed by a restore that must return the original selector pair, restore-enable against restore-disable on the flag, and an operation offered during the wait cycle that must be dropped. Periodic sweeps read every register back through the byte-read operations. These expose writes to the wrong byte or to the wrong register, which the selector outputs alone would not show.

// File: rtl/ptrf_pkg.sv
package ptrf_pkg;

  localparam int OPC_W = 4;

  typedef enum logic [OPC_W-1:0] {
    OPC_NOP  = 4'd0,
    OPC_INC  = 4'd1,
    OPC_DEC  = 4'd2,
    OPC_GLO  = 4'd3,
    OPC_GHI  = 4'd4,
    OPC_PLO  = 4'd5,
    OPC_PHI  = 4'd6,
    OPC_SETP = 4'd7,
    OPC_SETX = 4'd8,
    OPC_SAVE = 4'd9,
    OPC_RETE = 4'd10,
    OPC_RETD = 4'd11,
    OPC_PUSH = 4'd12,
    OPC_POP  = 4'd13
  } opc_e;

  // How the selected register is rewritten.
  typedef enum logic [1:0] {
    UPD_ADD1 = 2'd0,
    UPD_SUB1 = 2'd1,
    UPD_LOB  = 2'd2,
    UPD_HIB  = 2'd3
  } upd_e;

  // Which register index drives the shared access port.
  typedef enum logic [1:0] {
    SRC_NIB  = 2'd0,
    SRC_XPTR = 2'd1,
    SRC_STK  = 2'd2
  } src_e;

  typedef struct packed {
    logic reg_we;
    upd_e upd;
    src_e src;
    logic mem_we;
    logic wr_link;
    logic mem_re;
    logic p_load;
    logic x_load;
    logic save;
    logic restore;
    logic ie_val;
    logic get_lo;
    logic get_hi;
  } ctrl_t;

endpackage

// File: rtl/ptrf_rst_sync.sv
module ptrf_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/ptrf_decode.sv
module ptrf_decode
  import ptrf_pkg::*;
(
  input  logic [OPC_W-1:0] op_code,
  output ctrl_t            ctrl
);

  always_comb begin
    ctrl     = '0;
    ctrl.upd = UPD_ADD1;
    ctrl.src = SRC_NIB;
    case (op_code)
      OPC_INC: begin
        ctrl.reg_we = 1'b1;
        ctrl.upd    = UPD_ADD1;
      end
      OPC_DEC: begin
        ctrl.reg_we = 1'b1;
        ctrl.upd    = UPD_SUB1;
      end
      OPC_GLO:  ctrl.get_lo = 1'b1;
      OPC_GHI:  ctrl.get_hi = 1'b1;
      OPC_PLO: begin
        ctrl.reg_we = 1'b1;
        ctrl.upd    = UPD_LOB;
      end
      OPC_PHI: begin
        ctrl.reg_we = 1'b1;
        ctrl.upd    = UPD_HIB;
      end
      OPC_SETP: ctrl.p_load = 1'b1;
      OPC_SETX: ctrl.x_load = 1'b1;
      OPC_SAVE: begin
        ctrl.src     = SRC_STK;
        ctrl.reg_we  = 1'b1;
        ctrl.upd     = UPD_SUB1;
        ctrl.mem_we  = 1'b1;
        ctrl.wr_link = 1'b1;
        ctrl.save    = 1'b1;
      end
      OPC_RETE, OPC_RETD: begin
        ctrl.src     = SRC_XPTR;
        ctrl.reg_we  = 1'b1;
        ctrl.upd     = UPD_ADD1;
        ctrl.mem_re  = 1'b1;
        ctrl.restore = 1'b1;
        ctrl.ie_val  = (op_code == OPC_RETE);
      end
      OPC_PUSH: begin
        ctrl.src    = SRC_XPTR;
        ctrl.reg_we = 1'b1;
        ctrl.upd    = UPD_SUB1;
        ctrl.mem_we = 1'b1;
      end
      OPC_POP: begin
        ctrl.src    = SRC_XPTR;
        ctrl.reg_we = 1'b1;
        ctrl.upd    = UPD_ADD1;
        ctrl.mem_re = 1'b1;
      end
      default: ctrl = ctrl;
    endcase
  end

endmodule

// File: rtl/ptrf_bank.sv
module ptrf_bank #(
  parameter int IDX_W = 4,
  parameter int REG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] acc_idx,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data
);

  localparam int NREG = 1 << IDX_W;

  logic [REG_W-1:0] regs [NREG];

  for (genvar gi = 0; gi < NREG; gi++) begin : g_reg
    logic             we;
    logic [REG_W-1:0] q;

    assign we = wr_en && (acc_idx == IDX_W'(gi));

    if (gi == 0) begin : g_rst
      // Register 0 is the start-up program counter and needs a known value.
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          q <= '0;
        end else if (we) begin
          q <= wr_data;
        end
      end
    end else begin : g_nrst
      always_ff @(posedge clk) begin
        if (we) begin
          q <= wr_data;
        end
      end
    end

    assign regs[gi] = q;
  end

  assign rd_data = regs[acc_idx];

endmodule

// File: rtl/ptrf_ctl.sv
module ptrf_ctl
  import ptrf_pkg::*;
#(
  parameter int IDX_W  = 4,
  parameter int BYTE_W = 8,
  parameter int REG_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  ctrl_t             ctrl,
  input  logic [IDX_W-1:0]  op_n,
  input  logic [REG_W-1:0]  rd_data,
  input  logic [BYTE_W-1:0] mem_rdata,
  output logic [IDX_W-1:0]  p_q,
  output logic [IDX_W-1:0]  x_q,
  output logic [BYTE_W-1:0] t_q,
  output logic              ie_q,
  output logic              busy,
  output logic [BYTE_W-1:0] dout_q,
  output logic              dval_q
);

  typedef enum logic {ST_IDLE = 1'b0, ST_WAIT = 1'b1} st_e;
  typedef enum logic {PEND_LINK = 1'b0, PEND_DATA = 1'b1} pend_e;

  st_e               st_q, st_d;
  pend_e             pend_q, pend_d;
  logic [IDX_W-1:0]  p_d, x_d;
  logic [BYTE_W-1:0] t_d, dout_d;
  logic              ie_d, dval_d;
  logic              upd_en;

  // A state change happens only on a taken operation or in the wait cycle.
  assign upd_en = accept || (st_q == ST_WAIT);
  assign busy   = (st_q == ST_WAIT);

  always_comb begin
    st_d   = st_q;
    pend_d = pend_q;
    p_d    = p_q;
    x_d    = x_q;
    t_d    = t_q;
    ie_d   = ie_q;
    dout_d = dout_q;
    dval_d = 1'b0;
    if (st_q == ST_WAIT) begin
      st_d = ST_IDLE;
      if (pend_q == PEND_LINK) begin
        x_d = mem_rdata[BYTE_W-1 -: IDX_W];
        p_d = mem_rdata[IDX_W-1:0];
      end else begin
        dout_d = mem_rdata;
        dval_d = 1'b1;
      end
    end else if (accept) begin
      if (ctrl.p_load) p_d = op_n;
      if (ctrl.x_load) x_d = op_n;
      if (ctrl.save) begin
        t_d = BYTE_W'({x_q, p_q});
        x_d = p_q;
      end
      if (ctrl.restore) ie_d = ctrl.ie_val;
      if (ctrl.mem_re) begin
        st_d   = ST_WAIT;
        pend_d = ctrl.restore ? PEND_LINK : PEND_DATA;
      end
      if (ctrl.get_lo) begin
        dout_d = rd_data[BYTE_W-1:0];
        dval_d = 1'b1;
      end
      if (ctrl.get_hi) begin
        dout_d = rd_data[REG_W-1 -: BYTE_W];
        dval_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      pend_q <= PEND_LINK;
      p_q    <= '0;
      x_q    <= '0;
      t_q    <= '0;
      ie_q   <= 1'b1;
      dout_q <= '0;
      dval_q <= 1'b0;
    end else begin
      dval_q <= dval_d;
      if (upd_en) begin
        st_q   <= st_d;
        pend_q <= pend_d;
        p_q    <= p_d;
        x_q    <= x_d;
        t_q    <= t_d;
        ie_q   <= ie_d;
        dout_q <= dout_d;
      end
    end
  end

endmodule

// File: rtl/ptr_regfile.sv
module ptr_regfile
  import ptrf_pkg::*;
#(
  parameter int IDX_W     = 4,
  parameter int BYTE_W    = 8,
  parameter int STACK_IDX = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                op_valid,
  output logic                op_ready,
  input  logic [OPC_W-1:0]    op_code,
  input  logic [IDX_W-1:0]    op_n,
  input  logic [BYTE_W-1:0]   d_in,
  output logic [BYTE_W-1:0]   d_out,
  output logic                d_valid,
  output logic [2*BYTE_W-1:0] mem_addr,
  output logic                mem_we,
  output logic [BYTE_W-1:0]   mem_wdata,
  output logic                mem_re,
  input  logic [BYTE_W-1:0]   mem_rdata,
  output logic [IDX_W-1:0]    p_sel,
  output logic [IDX_W-1:0]    x_sel,
  output logic [BYTE_W-1:0]   t_reg,
  output logic                ie
);

  localparam int REG_W = 2 * BYTE_W;

  logic             rst_n_s;
  ctrl_t            ctrl;
  logic             accept;
  logic             busy;
  logic [IDX_W-1:0] acc_idx;
  logic [REG_W-1:0] rd_data;
  logic [REG_W-1:0] wr_data;

  ptrf_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  ptrf_decode u_dec (
    .op_code (op_code),
    .ctrl    (ctrl)
  );

  assign op_ready = !busy;
  assign accept   = op_valid && op_ready;

  // One shared access port: operand nibble, data pointer or the stack register.
  always_comb begin
    case (ctrl.src)
      SRC_XPTR: acc_idx = x_sel;
      SRC_STK:  acc_idx = IDX_W'(STACK_IDX);
      default:  acc_idx = op_n;
    endcase
  end

  always_comb begin
    case (ctrl.upd)
      UPD_SUB1: wr_data = rd_data - REG_W'(1);
      UPD_LOB:  wr_data = {rd_data[REG_W-1 -: BYTE_W], d_in};
      UPD_HIB:  wr_data = {d_in, rd_data[BYTE_W-1:0]};
      default:  wr_data = rd_data + REG_W'(1);
    endcase
  end

  ptrf_bank #(.IDX_W(IDX_W), .REG_W(REG_W)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .acc_idx (acc_idx),
    .wr_en   (accept && ctrl.reg_we),
    .wr_data (wr_data),
    .rd_data (rd_data)
  );

  ptrf_ctl #(.IDX_W(IDX_W), .BYTE_W(BYTE_W), .REG_W(REG_W)) u_ctl (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .accept    (accept),
    .ctrl      (ctrl),
    .op_n      (op_n),
    .rd_data   (rd_data),
    .mem_rdata (mem_rdata),
    .p_q       (p_sel),
    .x_q       (x_sel),
    .t_q       (t_reg),
    .ie_q      (ie),
    .busy      (busy),
    .dout_q    (d_out),
    .dval_q    (d_valid)
  );

  assign mem_addr  = rd_data;
  assign mem_we    = accept && ctrl.mem_we;
  assign mem_re    = accept && ctrl.mem_re;
  assign mem_wdata = ctrl.wr_link ? BYTE_W'({x_sel, p_sel}) : d_in;

endmodule

// File: rtl/ptrf_checker.sv
module ptrf_checker #(
  parameter int IDX_W  = 4,
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              op_valid,
  input logic              op_ready,
  input logic [3:0]        op_code,
  input logic [IDX_W-1:0]  op_n,
  input logic              d_valid,
  input logic              mem_we,
  input logic              mem_re,
  input logic [BYTE_W-1:0] mem_wdata,
  input logic [IDX_W-1:0]  p_sel,
  input logic [IDX_W-1:0]  x_sel,
  input logic [BYTE_W-1:0] t_reg,
  input logic              ie
);

  logic taken;
  assign taken = op_valid && op_ready;

  AST_GET_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (taken && (op_code == 4'd3 || op_code == 4'd4)) |=> d_valid); // R3

  AST_SETP_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (taken && op_code == 4'd7) |=> (p_sel == $past(op_n))); // R5

  AST_SETX_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (taken && op_code == 4'd8) |=> (x_sel == $past(op_n))); // R5

  AST_SAVE_WRITES_LINK: assert property (@(posedge clk) disable iff (!rst_n)
    (taken && op_code == 4'd9) |-> (mem_we && !mem_re && mem_wdata == BYTE_W'({x_sel, p_sel}))); // R6

  AST_SAVE_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
    (taken && op_code == 4'd9) |=> (t_reg == $past(BYTE_W'({x_sel, p_sel})) && x_sel == $past(p_sel))); // R6

  AST_MEM_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re)); // R6

  AST_RETE_SETS_IE: assert property (@(posedge clk) disable iff (!rst_n)
    (taken && op_code == 4'd10) |=> ie); // R7

  AST_RETD_CLEARS_IE: assert property (@(posedge clk) disable iff (!rst_n)
    (taken && op_code == 4'd11) |=> !ie); // R7

  AST_READ_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    (taken && (op_code == 4'd10 || op_code == 4'd11 || op_code == 4'd13)) |=> !op_ready); // R10

  AST_STALL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    !op_ready |=> op_ready); // R10

  AST_UNUSED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (taken && (op_code == 4'd0 || op_code >= 4'd14)) |=>
      (p_sel == $past(p_sel) && x_sel == $past(x_sel) && t_reg == $past(t_reg) && ie == $past(ie))); // R11

  AST_UNUSED_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    (taken && (op_code == 4'd0 || op_code >= 4'd14)) |-> (!mem_we && !mem_re)); // R11

endmodule

bind ptr_regfile ptrf_checker #(.IDX_W(IDX_W), .BYTE_W(BYTE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .op_valid  (op_valid),
  .op_ready  (op_ready),
  .op_code   (op_code),
  .op_n      (op_n),
  .d_valid   (d_valid),
  .mem_we    (mem_we),
  .mem_re    (mem_re),
  .mem_wdata (mem_wdata),
  .p_sel     (p_sel),
  .x_sel     (x_sel),
  .t_reg     (t_reg),
  .ie        (ie)
);

// File: tb/ptr_regfile_tb.sv
module ptr_regfile_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic        op_ready;
  logic [3:0]  op_code = '0;
  logic [3:0]  op_n = '0;
  logic [7:0]  d_in = '0;
  logic [7:0]  d_out;
  logic        d_valid;
  logic [15:0] mem_addr;
  logic        mem_we;
  logic [7:0]  mem_wdata;
  logic        mem_re;
  logic [7:0]  mem_rdata;
  logic [3:0]  p_sel;
  logic [3:0]  x_sel;
  logic [7:0]  t_reg;
  logic        ie;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  ptr_regfile dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_valid  (op_valid),
    .op_ready  (op_ready),
    .op_code   (op_code),
    .op_n      (op_n),
    .d_in      (d_in),
    .d_out     (d_out),
    .d_valid   (d_valid),
    .mem_addr  (mem_addr),
    .mem_we    (mem_we),
    .mem_wdata (mem_wdata),
    .mem_re    (mem_re),
    .mem_rdata (mem_rdata),
    .p_sel     (p_sel),
    .x_sel     (x_sel),
    .t_reg     (t_reg),
    .ie        (ie)
  );

  function automatic logic [7:0] fill_byte(input int a);
    return 8'((a * 29 + 91) ^ (a >> 2));
  endfunction

  // Environment memory (256 bytes, aliased on address bits 7:0), filled during reset.
  logic [7:0] mem [256];
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= fill_byte(i);
    end else begin
      if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
      if (mem_re) mem_rdata <= mem[mem_addr[7:0]];
    end
  end

  // Reference model.
  logic [15:0] m_r [16];
  logic [7:0]  m_mem [256];
  logic [3:0]  m_p, m_x;
  logic [7:0]  m_t;
  logic        m_ie;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic chk_state(input string req);
    chk({req, " p_sel"}, 32'(p_sel), 32'(m_p));
    chk({req, " x_sel"}, 32'(x_sel), 32'(m_x));
    chk({req, " t_reg"}, 32'(t_reg), 32'(m_t));
    chk({req, " ie"},    32'(ie),    32'(m_ie));
  endtask

  function automatic string tag_of(input logic [3:0] c);
    case (c)
      4'd1, 4'd2:   return "R2";
      4'd3, 4'd4:   return "R3";
      4'd5, 4'd6:   return "R4";
      4'd7, 4'd8:   return "R5";
      4'd9:         return "R6";
      4'd10, 4'd11: return "R7";
      4'd12:        return "R8";
      4'd13:        return "R9";
      default:      return "R11";
    endcase
  endfunction

  task automatic run_op(input logic [3:0] code, input logic [3:0] n, input logic [7:0] d,
                        output logic [7:0] got);
    logic       expv = 1'b0;
    logic [7:0] expd = '0;
    logic       wchk = 1'b0;
    logic [7:0] waddr = '0;
    logic [7:0] b;
    string      tg = tag_of(code);
    case (code)
      4'd1: m_r[n] = m_r[n] + 16'd1;
      4'd2: m_r[n] = m_r[n] - 16'd1;
      4'd3: begin expv = 1'b1; expd = m_r[n][7:0]; end
      4'd4: begin expv = 1'b1; expd = m_r[n][15:8]; end
      4'd5: m_r[n][7:0] = d;
      4'd6: m_r[n][15:8] = d;
      4'd7: m_p = n;
      4'd8: m_x = n;
      4'd9: begin
        waddr = m_r[2][7:0]; wchk = 1'b1;
        m_mem[waddr] = {m_x, m_p};
        m_t = {m_x, m_p};
        m_x = m_p;
        m_r[2] = m_r[2] - 16'd1;
      end
      4'd10, 4'd11: begin
        b = m_mem[m_r[m_x][7:0]];
        m_r[m_x] = m_r[m_x] + 16'd1;
        m_x = b[7:4];
        m_p = b[3:0];
        m_ie = (code == 4'd10);
      end
      4'd12: begin
        waddr = m_r[m_x][7:0]; wchk = 1'b1;
        m_mem[waddr] = d;
        m_r[m_x] = m_r[m_x] - 16'd1;
      end
      4'd13: begin
        expv = 1'b1; expd = m_mem[m_r[m_x][7:0]];
        m_r[m_x] = m_r[m_x] + 16'd1;
      end
      default: ;
    endcase
    @(negedge clk);
    op_valid = 1'b1; op_code = code; op_n = n; d_in = d;
    @(negedge clk);
    op_valid = 1'b0;
    got = d_out;
    if (code == 4'd10 || code == 4'd11 || code == 4'd13) begin
      chk("R10 op_ready low in wait cycle", 32'(op_ready), 32'd0);
      if (code == 4'd13) chk("R9 no early d_valid", 32'(d_valid), 32'd0);
      @(negedge clk);
      got = d_out;
      chk("R10 op_ready back high", 32'(op_ready), 32'd1);
    end
    chk({tg, " d_valid"}, 32'(d_valid), 32'(expv));
    if (expv) chk({tg, " d_out"}, 32'(d_out), 32'(expd));
    if (wchk) chk({tg, " memory byte"}, 32'(mem[waddr]), 32'(m_mem[waddr]));
    chk_state(tg);
  endtask

  task automatic read_reg(input logic [3:0] n, output logic [15:0] v);
    logic [7:0] lo, hi;
    run_op(4'd3, n, 8'h00, lo);
    run_op(4'd4, n, 8'h00, hi);
    v = {hi, lo};
  endtask

  task automatic write_reg(input logic [3:0] n, input logic [15:0] v);
    logic [7:0] g;
    run_op(4'd5, n, v[7:0], g);
    run_op(4'd6, n, v[15:8], g);
  endtask

  task automatic sweep();
    logic [15:0] v;
    for (int i = 0; i < 16; i++) read_reg(4'(i), v);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : main
    logic [15:0] v;
    logic [7:0]  g;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 256; i++) m_mem[i] = fill_byte(i);
    m_p = '0; m_x = '0; m_t = '0; m_ie = 1'b1;
    for (int i = 0; i < 16; i++) m_r[i] = '0;

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    chk("R1 p_sel", 32'(p_sel), 32'd0);
    chk("R1 x_sel", 32'(x_sel), 32'd0);
    chk("R1 t_reg", 32'(t_reg), 32'd0);
    chk("R1 ie", 32'(ie), 32'd1);
    chk("R1 op_ready", 32'(op_ready), 32'd1);
    chk("R1 d_valid", 32'(d_valid), 32'd0);
    read_reg(4'd0, v);
    chk("R1 register 0", 32'(v), 32'h0000);

    // Seed every register with a random value.
    for (int i = 0; i < 16; i++) write_reg(4'(i), 16'($urandom));
    sweep();

    // R4: byte writes leave the other byte alone
    write_reg(4'd9, 16'hA55A);
    run_op(4'd5, 4'd9, 8'h3C, g);
    read_reg(4'd9, v);
    chk("R4 low byte write", 32'(v), 32'hA53C);
    run_op(4'd6, 4'd9, 8'hC3, g);
    read_reg(4'd9, v);
    chk("R4 high byte write", 32'(v), 32'hC33C);

    // R2: wrap at both ends
    write_reg(4'd7, 16'hFFFF);
    run_op(4'd1, 4'd7, 8'h00, g);
    read_reg(4'd7, v);
    chk("R2 increment wraps", 32'(v), 32'h0000);
    run_op(4'd2, 4'd7, 8'h00, g);
    read_reg(4'd7, v);
    chk("R2 decrement wraps", 32'(v), 32'hFFFF);

    // R6 then R7: save and restore return the selector pair
    write_reg(4'd2, 16'h1240);
    run_op(4'd7, 4'd5, 8'h00, g);
    run_op(4'd8, 4'd3, 8'h00, g);
    run_op(4'd11, 4'd0, 8'h00, g);   // fetch through R3: only the flag matters here
    chk("R7 disable clears ie", 32'(ie), 32'd0);
    run_op(4'd7, 4'd5, 8'h00, g);
    run_op(4'd8, 4'd3, 8'h00, g);
    run_op(4'd9, 4'd0, 8'h00, g);
    chk("R6 link byte in memory", 32'(mem[8'h40]), 32'h35);
    chk("R6 t_reg", 32'(t_reg), 32'h35);
    chk("R6 x_sel takes p_sel", 32'(x_sel), 32'h5);
    read_reg(4'd2, v);
    chk("R6 stack register decremented", 32'(v), 32'h123F);
    run_op(4'd8, 4'd2, 8'h00, g);
    run_op(4'd1, 4'd2, 8'h00, g);
    run_op(4'd10, 4'd0, 8'h00, g);
    chk("R7 restored x_sel", 32'(x_sel), 32'h3);
    chk("R7 restored p_sel", 32'(p_sel), 32'h5);
    chk("R7 enable sets ie", 32'(ie), 32'd1);
    read_reg(4'd2, v);
    chk("R7 old pointer incremented", 32'(v), 32'h1241);

    // R8 and R9: store then load through the data pointer
    write_reg(4'd6, 16'h0080);
    run_op(4'd8, 4'd6, 8'h00, g);
    run_op(4'd12, 4'd0, 8'hE7, g);
    chk("R8 stored byte", 32'(mem[8'h80]), 32'hE7);
    run_op(4'd1, 4'd6, 8'h00, g);
    run_op(4'd13, 4'd0, 8'h00, g);
    chk("R9 loaded byte", 32'(g), 32'hE7);
    read_reg(4'd6, v);
    chk("R9 pointer advanced", 32'(v), 32'h0081);

    // R10: an operation offered during the wait cycle is dropped
    write_reg(4'd5, 16'h0505);
    m_r[6] = m_r[6] + 16'd1;
    @(negedge clk);
    op_valid = 1'b1; op_code = 4'd13; op_n = 4'd0;
    @(negedge clk);
    op_code = 4'd1; op_n = 4'd5;
    chk("R10 busy while offered", 32'(op_ready), 32'd0);
    @(negedge clk);
    op_valid = 1'b0;
    chk("R9 d_valid on load", 32'(d_valid), 32'd1);
    chk("R9 d_out on load", 32'(d_out), 32'(m_mem[8'h81]));
    read_reg(4'd5, v);
    chk("R10 offered increment ignored", 32'(v), 32'h0505);

    // R11: unused codes
    run_op(4'd14, 4'd4, 8'hFF, g);
    run_op(4'd15, 4'd2, 8'h11, g);
    run_op(4'd0, 4'd1, 8'h22, g);
    sweep();

    // Random mix of every code.
    for (int k = 0; k < 400; k++) begin
      run_op(4'($urandom_range(0, 15)), 4'($urandom_range(0, 15)), 8'($urandom), g);
      if (k % 80 == 79) sweep();
    end
    sweep();

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule